// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum-Number Unit

This block returns the smaller or the larger of two floating-point operands under minimum-number and maximum-number rules, in binary32 or binary64. A NaN operand counts as a missing value, so the other operand wins. Two zeros that compare equal are separated by their sign bits, never by which input they arrived on. The block works directly on bit patterns, with an unsigned comparison of the magnitude fields and the sign bits handled on the side. It uses no arithmetic, so subnormals are ordered exactly.

Each operand bus is 64 bits wide. In binary32 mode the operand sits in the low 32 bits. An operation presented with `in_valid` high produces its registered result one clock later with `out_valid` high. A NaN result always leaves the block quiet, and any payload bits it carries are kept.

Top module: `fp_minmax_nm`

## Requirements
- R1: `out_valid` equals the `in_valid` of the previous clock. A synchronous active-high `rst` drives `out_valid` low.
- R2: `dbl_sel`=1 selects binary64 and `dbl_sel`=0 selects binary32, with the operand in bits [31:0]. `min_sel`=1 returns the numerically smaller operand and `min_sel`=0 returns the larger. This holds in either operand order.
- R3: For a +0 and a -0 in either order, the minimum is -0 and the maximum is +0.
- R4: Two zeros of the same sign give that same zero for both the minimum and the maximum.
- R5: When exactly one operand is a NaN, the result is the other operand, for both the minimum and the maximum. A NaN has an all-ones exponent and a non-zero fraction.
- R6: When both operands are NaN, the result is operand A's NaN with its payload kept. This holds for both the minimum and the maximum.
- R7: A NaN result always has the fraction MSB set: bit 51 in binary64, bit 22 in binary32. A signalling NaN has that bit cleared on input. All other bits of a NaN result are kept.
- R8: In binary32 mode, `out_res[63:32]` is zero. Bits [63:32] of both operands have no effect on the result.
- R9: Subnormal operands are ordered exactly by their bit patterns and are not flushed to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| dbl_sel | input | 1 | 1 = binary64, 0 = binary32 |
| min_sel | input | 1 | 1 = minimum, 0 = maximum |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_res | output | 64 | Registered result |

## Verification
The assertions check the result only in the cycle after an accepted operation. They rely on `dbl_sel`, `min_sel` and both operands being stable and defined while `in_valid` is high. They place no requirement on those inputs when `in_valid` is low. The stimulus changes inputs only on falling edges. Between operations it leaves idle gaps with `in_valid` low. In binary32 cases it fills the upper operand bits with random garbage, so those bits are exercised without becoming part of the operand.

// File: rtl/fp_minmax_nm.sv
module fp_minmax_nm (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic        dbl_sel,
  input  logic        min_sel,
  input  logic [63:0] op_a,
  input  logic [63:0] op_b,
  output logic        out_valid,
  output logic [63:0] out_res
);
  logic        sa, sb, na, nb;
  logic [62:0] ma, mb;
  logic        both_zero, a_less, b_less, take_b, sel_nan;
  logic [63:0] sel, qbit, res;

  assign sa = dbl_sel ? op_a[63] : op_a[31];
  assign sb = dbl_sel ? op_b[63] : op_b[31];
  assign ma = dbl_sel ? op_a[62:0] : {32'b0, op_a[30:0]};
  assign mb = dbl_sel ? op_b[62:0] : {32'b0, op_b[30:0]};

  assign na = dbl_sel ? (&op_a[62:52] & |op_a[51:0]) : (&op_a[30:23] & |op_a[22:0]);
  assign nb = dbl_sel ? (&op_b[62:52] & |op_b[51:0]) : (&op_b[30:23] & |op_b[22:0]);

  assign both_zero = (ma == '0) && (mb == '0);

  always_comb begin
    if (both_zero)     a_less = 1'b0;
    else if (sa != sb) a_less = sa;
    else if (sa)       a_less = ma > mb;
    else               a_less = ma < mb;
    if (both_zero)     b_less = 1'b0;
    else if (sa != sb) b_less = sb;
    else if (sb)       b_less = mb > ma;
    else               b_less = mb < ma;
  end

  always_comb begin
    if (na && nb)    take_b = 1'b0;
    else if (na)     take_b = 1'b1;
    else if (nb)     take_b = 1'b0;
    else if (min_sel) take_b = b_less | (!a_less & !sa);
    else             take_b = a_less | (!b_less & sa);
  end

  assign sel     = take_b ? op_b : op_a;
  assign sel_nan = take_b ? nb : na;
  assign qbit    = dbl_sel ? 64'h0008_0000_0000_0000 : 64'h0000_0000_0040_0000;
  assign res     = (dbl_sel ? sel : {32'b0, sel[31:0]}) | (sel_nan ? qbit : 64'b0);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_res   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_res <= res;
    end
  end
endmodule

module fp_minmax_nm_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        dbl_sel,
  input logic        min_sel,
  input logic [63:0] op_a,
  input logic [63:0] op_b,
  input logic        out_valid,
  input logic [63:0] out_res
);
  logic [63:0] a_lo, b_lo;
  logic        a_is_nan, b_is_nan, res_nan64, res_nan32;

  assign a_lo = dbl_sel ? op_a : {32'b0, op_a[31:0]};
  assign b_lo = dbl_sel ? op_b : {32'b0, op_b[31:0]};
  assign a_is_nan = dbl_sel ? ({1'b0, op_a[62:0]} > 64'h7ff0_0000_0000_0000)
                            : ({33'b0, op_a[30:0]} > 64'h7f80_0000);
  assign b_is_nan = dbl_sel ? ({1'b0, op_b[62:0]} > 64'h7ff0_0000_0000_0000)
                            : ({33'b0, op_b[30:0]} > 64'h7f80_0000);
  assign res_nan64 = {1'b0, out_res[62:0]} > 64'h7ff0_0000_0000_0000;
  assign res_nan32 = {33'b0, out_res[30:0]} > 64'h7f80_0000;

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R1
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dbl_sel) |=> (out_res[63:32] == 32'b0)); // R8
  AST_QUIET64: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dbl_sel) |=> (!res_nan64 || out_res[51])); // R7
  AST_QUIET32: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dbl_sel) |=> (!res_nan32 || out_res[22])); // R7
  AST_ONE_NAN_B: assert property (@(posedge clk) disable iff (rst)
    (in_valid && a_is_nan && !b_is_nan) |=> (out_res == $past(b_lo))); // R5
  AST_ONE_NAN_A: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !a_is_nan && b_is_nan) |=> (out_res == $past(a_lo))); // R5
  AST_PICK_OPERAND: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !a_is_nan && !b_is_nan) |=> (out_res == $past(a_lo) || out_res == $past(b_lo))); // R2
endmodule

bind fp_minmax_nm fp_minmax_nm_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .dbl_sel(dbl_sel), .min_sel(min_sel),
  .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .out_res(out_res)
);

// File: tb/tb_fp_minmax_nm.sv
module tb_fp_minmax_nm;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        dbl_sel = 1'b1;
  logic        min_sel = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        out_valid;
  logic [63:0] out_res;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  logic        m_valid = 1'b0;
  logic        m_dbl = 1'b1;
  logic [63:0] m_res = '0;
  string       m_tag = "R2";

  always #4 clk = ~clk;

  fp_minmax_nm dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .dbl_sel(dbl_sel), .min_sel(min_sel),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .out_res(out_res)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] key_of(input logic [63:0] x, input logic [63:0] sgn);
    logic [63:0] full;
    full = sgn | (sgn - 64'd1);
    return ((x & sgn) != 0) ? (~x & full) : (x | sgn);
  endfunction

  function automatic logic [63:0] ref_nm(input logic dbl, input logic mn,
                                         input logic [63:0] a_in, input logic [63:0] b_in,
                                         output string tag);
    logic [63:0] a, b, sgn, qb, inf, minnorm, r, ka, kb;
    logic na, nb, nr;
    sgn     = dbl ? 64'h8000_0000_0000_0000 : 64'h8000_0000;
    qb      = dbl ? 64'h0008_0000_0000_0000 : 64'h0040_0000;
    inf     = dbl ? 64'h7ff0_0000_0000_0000 : 64'h7f80_0000;
    minnorm = dbl ? 64'h0010_0000_0000_0000 : 64'h0080_0000;
    a = dbl ? a_in : {32'h0, a_in[31:0]};
    b = dbl ? b_in : {32'h0, b_in[31:0]};
    na = (a & ~sgn) > inf;
    nb = (b & ~sgn) > inf;
    tag = "R2";
    if ((a & ~sgn) == 0 && (b & ~sgn) == 0) tag = (a == b) ? "R4" : "R3";
    else if (((a & ~sgn) != 0 && (a & ~sgn) < minnorm) ||
             ((b & ~sgn) != 0 && (b & ~sgn) < minnorm)) tag = "R9";
    if (na && nb) begin r = a; tag = "R6"; end
    else if (na) begin r = b; tag = "R5"; end
    else if (nb) begin r = a; tag = "R5"; end
    else begin
      ka = key_of(a, sgn);
      kb = key_of(b, sgn);
      if (mn) r = (ka <= kb) ? a : b;
      else    r = (ka >= kb) ? a : b;
    end
    nr = (r & ~sgn) > inf;
    if (nr && (r & qb) == 0) tag = "R7";
    if (nr) r = r | qb;
    return r;
  endfunction

  always @(posedge clk) begin
    string t;
    logic [63:0] r;
    if (rst) m_valid = 1'b0;
    else begin
      m_valid = in_valid;
      if (in_valid) begin
        r = ref_nm(dbl_sel, min_sel, op_a, op_b, t);
        m_res = r;
        m_tag = t;
        m_dbl = dbl_sel;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R1", {63'b0, out_valid}, {63'b0, m_valid});
      if (m_valid) begin
        chk(m_tag, out_res, m_res);
        if (!m_dbl) chk("R8", {32'b0, out_res[63:32]}, 64'b0);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL R1 watchdog actual=%0d expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic op(input logic dbl, input logic mn, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    dbl_sel = dbl;
    min_sel = mn;
    op_a = a;
    op_b = b;
  endtask

  task automatic both(input logic dbl, input logic [63:0] a, input logic [63:0] b);
    op(dbl, 1'b1, a, b);
    op(dbl, 1'b0, a, b);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_a = {$urandom, $urandom};
    end
  endtask

  function automatic logic [63:0] gen(input logic dbl, input logic [63:0] other);
    logic [63:0] v, rnd;
    logic s;
    rnd = {$urandom, $urandom};
    s = rnd[63];
    case ($urandom % 7)
      0: v = rnd;
      1: v = dbl ? {s, 63'b0} : {32'b0, s, 31'b0};
      2: v = dbl ? {s, 11'h7ff, rnd[51:1], 1'b1} : {32'b0, s, 8'hff, rnd[22:1], 1'b1};
      3: v = dbl ? {s, 11'h0, rnd[51:0]} : {32'b0, s, 8'h0, rnd[22:0]};
      4: v = dbl ? {s, 11'h7ff, 52'b0} : {32'b0, s, 8'hff, 23'b0};
      5: v = dbl ? {s, 11'h3ff, 49'b0, rnd[2:0]} : {32'b0, s, 8'h7f, 20'b0, rnd[2:0]};
      default: v = other;
    endcase
    if (!dbl) v[63:32] = $urandom;
    return v;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {63'b0, out_valid}, 64'b0);
    rst = 1'b0;
    // binary64 directed cases
    both(1, 64'h3ff0_0000_0000_0000, 64'hbff0_0000_0000_0000);
    both(1, 64'hbff0_0000_0000_0000, 64'h3ff0_0000_0000_0000);
    both(1, 64'h8000_0000_0000_0000, 64'hbff0_0000_0000_0000);
    both(1, 64'h0000_0000_0000_0000, 64'h3ff0_0000_0000_0000);
    both(1, 64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000);
    both(1, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000);
    both(1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000);
    both(1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
    both(1, 64'h0000_0000_0000_0000, 64'h7ff8_0000_0000_0001);
    both(1, 64'h7ff8_0000_0000_0001, 64'h0000_0000_0000_0000);
    both(1, 64'h7ff8_0000_0000_0001, 64'h7ff8_0000_0000_0002);
    both(1, 64'h7ff8_0000_0000_0002, 64'h7ff8_0000_0000_0001);
    both(1, 64'h7ff0_0000_0000_0005, 64'h7ff8_0000_0000_0002);
    both(1, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002);
    both(1, 64'h8000_0000_0000_0002, 64'h8000_0000_0000_0001);
    idle(2);
    // binary32 directed cases with garbage in the upper bits
    both(0, 64'hdead_beef_3f80_0000, 64'h1234_5678_bf80_0000);
    both(0, 64'hffff_ffff_8000_0000, 64'h0000_0001_0000_0000);
    both(0, 64'h0000_0000_7fc0_0001, 64'hffff_0000_0000_0000);
    both(0, 64'h0000_0000_7fc0_0001, 64'h0000_0000_7fc0_0002);
    both(0, 64'ha5a5_a5a5_7f80_0001, 64'h0000_0000_3f80_0000);
    both(0, 64'h0000_0000_ff80_0003, 64'h5a5a_5a5a_7fa0_0000);
    both(0, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0002);
    idle(3);
    // mixed random operations with gaps
    for (int i = 0; i < 600; i++) begin
      logic d;
      logic [63:0] a;
      d = $urandom % 2 == 1;
      a = gen(d, 64'h0);
      op(d, $urandom % 2 == 1, a, gen(d, a));
      if ($urandom % 5 == 0) idle(1);
    end
    idle(3);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule